// File: doc/BRIEF.md
# I2C Slave Memory Access Port

This block lets an external I2C master reach an on-chip byte memory as if it were a serial memory device. It only ever acts as a target on the bus: it never drives the clock line and pulls the data line low only through an open-drain enable. Its 7-bit bus address comes from seven strap inputs, so several instances can share one bus.

A transfer begins with a START and an address byte. When the address matches the straps, the lowest bit of that byte selects the direction. In a write transfer, the first two bytes that follow set an internal address pointer. Every byte after those is stored at the pointer, and the pointer then advances. To read, the master sends a repeated START followed by the address with the direction bit set. The block then streams bytes from the current pointer until the master declines a byte. Both bus lines are synchronised to the system clock and filtered before any bus event is decoded.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, `sda_drive_low_o` is 0, `mem_we_o` is 0 and `mem_addr_o` is 0.
- R2: When the first byte after a START carries the strap value `dev_addr_i` in its upper seven bits (most significant bit first), the block pulls SDA low in the ninth clock. Bit 0 of that byte selects the direction: 0 means write and 1 means read.
- R3: When the address does not match, the block does not pull SDA low in the ninth clock. Until the next START it acknowledges no byte and writes nothing.
- R4: In a write transfer, the first byte after the address sets pointer bits AW-1..8 from its low AW-8 bits. The second byte sets pointer bits 7..0. The block acknowledges both bytes.
- R5: Each further written byte is acknowledged and stored by a single-cycle `mem_we_o` pulse at the pointer. The pointer increases by one on the next cycle.
- R6: In a read transfer, each byte is taken from the current pointer and shifted out most significant bit first. The pointer increases by one after each byte.
- R7: When the master does not acknowledge a read byte, the transfer ends. SDA stays released until the next START.
- R8: The pointer wraps from 2^AW-1 to 0, for both writes and reads.
- R9: A falling SDA while SCL is high is a START, and this includes a repeated START. A rising SDA while SCL is high is a STOP, which returns the block to idle.
- R10: A pulse on SCL or SDA shorter than FILT_LEN clock cycles has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_addr_i | input | 7 | Strapped 7-bit bus address |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| mem_addr_o | output | AW | Memory address, equal to the current pointer |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Single-cycle write strobe |
| mem_rdata_i | input | 8 | Read data for `mem_addr_o`, with at most one cycle of latency |

## Verification
The bench builds the block with AW=9, which gives a 512-byte space. At that size the pointer high byte carries a single meaningful bit, and the wrap from 511 to 0 is reached within two data bytes. FILT_LEN=3 is chosen so that the bench's two-cycle glitches on SCL and SDA fall just below the rejection threshold. A bus half-period of 12 system clocks leaves margin over the synchroniser and filter delay. Under those settings, seeded random transfers with random straps, pointers and lengths run alongside directed mismatch, mid-transfer STOP, wrap and glitch cases.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_ADDR = 3'd1,
      S_AACK = 3'd2,
      S_WR   = 3'd3,
      S_WACK = 3'd4,
      S_RD   = 3'd5,
      S_RACK = 3'd6
   } slv_state_e;

   typedef enum logic [1:0] {
      PH_PTR_HI = 2'd0,
      PH_PTR_LO = 2'd1,
      PH_DATA   = 2'd2
   } wr_phase_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   logic [1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], line_i};
   end

   generate
      if (FILT_LEN == 1) begin : g_bypass
         assign line_o = sync_q[1];
      end else begin : g_window
         logic [FILT_LEN-1:0] win_q;
         logic                out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q <= '1;
               out_q <= 1'b1;
            end else begin
               win_q <= {win_q[FILT_LEN-2:0], sync_q[1]};
               if (&win_q)       out_q <= 1'b1;
               else if (~|win_q) out_q <= 1'b0;
            end
         end
         assign line_o = out_q;
      end
   endgenerate

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign start_o    = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_o     = scl_f & scl_q & ~sda_q & sda_f;
   assign scl_rise_o = scl_f & ~scl_q;
   assign scl_fall_o = ~scl_f & scl_q;

endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
   import i2c_mem_pkg::*;
#(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic          scl_rise_i,
   input  logic          scl_fall_i,
   input  logic          sda_i,
   input  logic [6:0]    dev_addr_i,
   input  logic [7:0]    mem_rdata_i,
   output logic          sda_low_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [7:0]    mem_wdata_o,
   output logic          mem_we_o,
   output slv_state_e    state_o,
   output logic [7:0]    shift_o
);

   localparam int HI_BITS = AW - 8;

   slv_state_e    state_q;
   wr_phase_e     phase_q;
   logic [3:0]    cnt_q;
   logic [7:0]    sh_q;
   logic          rw_q, nack_q, sda_low_q, we_q;
   logic [7:0]    wdata_q;
   logic [AW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         phase_q   <= PH_PTR_HI;
         cnt_q     <= '0;
         sh_q      <= '0;
         rw_q      <= 1'b0;
         nack_q    <= 1'b0;
         sda_low_q <= 1'b0;
         we_q      <= 1'b0;
         wdata_q   <= '0;
         ptr_q     <= '0;
      end else begin
         we_q <= 1'b0;
         if (we_q) ptr_q <= ptr_q + 1'b1;
         if (stop_i) begin
            state_q   <= S_IDLE;
            sda_low_q <= 1'b0;
         end else if (start_i) begin
            state_q   <= S_ADDR;
            cnt_q     <= '0;
            sda_low_q <= 1'b0;
         end else begin
            case (state_q)
               S_ADDR: begin
                  if (scl_rise_i) begin
                     sh_q  <= {sh_q[6:0], sda_i};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall_i && cnt_q == 4'd8) begin
                     cnt_q <= '0;
                     if (sh_q[7:1] == dev_addr_i) begin
                        sda_low_q <= 1'b1;
                        rw_q      <= sh_q[0];
                        state_q   <= S_AACK;
                     end else begin
                        state_q <= S_IDLE;
                     end
                  end
               end
               S_AACK, S_RACK: begin
                  if (scl_rise_i) nack_q <= sda_i;
                  if (scl_fall_i) begin
                     if (state_q == S_AACK && !rw_q) begin
                        sda_low_q <= 1'b0;
                        phase_q   <= PH_PTR_HI;
                        state_q   <= S_WR;
                     end else if (state_q == S_RACK && nack_q) begin
                        state_q <= S_IDLE;
                     end else begin
                        sh_q      <= mem_rdata_i;
                        sda_low_q <= ~mem_rdata_i[7];
                        cnt_q     <= 4'd1;
                        state_q   <= S_RD;
                     end
                  end
               end
               S_WR: begin
                  if (scl_rise_i) begin
                     sh_q  <= {sh_q[6:0], sda_i};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall_i && cnt_q == 4'd8) begin
                     cnt_q     <= '0;
                     sda_low_q <= 1'b1;
                     state_q   <= S_WACK;
                     case (phase_q)
                        PH_PTR_HI: begin
                           ptr_q[AW-1:8] <= sh_q[HI_BITS-1:0];
                           phase_q       <= PH_PTR_LO;
                        end
                        PH_PTR_LO: begin
                           ptr_q[7:0] <= sh_q;
                           phase_q    <= PH_DATA;
                        end
                        default: begin
                           we_q    <= 1'b1;
                           wdata_q <= sh_q;
                        end
                     endcase
                  end
               end
               S_WACK: begin
                  if (scl_fall_i) begin
                     sda_low_q <= 1'b0;
                     state_q   <= S_WR;
                  end
               end
               S_RD: begin
                  if (scl_fall_i) begin
                     if (cnt_q == 4'd8) begin
                        sda_low_q <= 1'b0;
                        state_q   <= S_RACK;
                        ptr_q     <= ptr_q + 1'b1;
                     end else begin
                        sda_low_q <= ~sh_q[6];
                        sh_q      <= {sh_q[6:0], 1'b0};
                        cnt_q     <= cnt_q + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_low_o   = sda_low_q;
   assign mem_addr_o  = ptr_q;
   assign mem_wdata_o = wdata_q;
   assign mem_we_o    = we_q;
   assign state_o     = state_q;
   assign shift_o     = sh_q;

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
   import i2c_mem_pkg::*;
#(
   parameter int AW       = 11,
   parameter int FILT_LEN = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   input  logic [6:0]    dev_addr_i,
   output logic          sda_drive_low_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [7:0]    mem_wdata_o,
   output logic          mem_we_o,
   input  logic [7:0]    mem_rdata_i
);

   localparam int N_LINES = 2;

   generate
      if (AW < 9 || AW > 16) begin : g_bad_aw
         $error("i2c_mem_slave: AW must lie in 9..16");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("i2c_mem_slave: FILT_LEN must be at least 1");
      end
   endgenerate

   logic [N_LINES-1:0] raw_w, filt_w;
   logic               start_w, stop_w, rise_w, fall_w;
   slv_state_e         state_w;
   logic [7:0]         shift_w;

   assign raw_w = {scl_i, sda_i};

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_line
         i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_w[g]),
            .line_o (filt_w[g])
         );
      end
   endgenerate

   i2c_bus_events u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_f      (filt_w[1]),
      .sda_f      (filt_w[0]),
      .start_o    (start_w),
      .stop_o     (stop_w),
      .scl_rise_o (rise_w),
      .scl_fall_o (fall_w)
   );

   i2c_slave_engine #(.AW(AW)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_w),
      .stop_i      (stop_w),
      .scl_rise_i  (rise_w),
      .scl_fall_i  (fall_w),
      .sda_i       (filt_w[0]),
      .dev_addr_i  (dev_addr_i),
      .mem_rdata_i (mem_rdata_i),
      .sda_low_o   (sda_drive_low_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .mem_we_o    (mem_we_o),
      .state_o     (state_w),
      .shift_o     (shift_w)
   );

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
   import i2c_mem_pkg::*;
#(
   parameter int AW = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sda_low,
   input logic          we,
   input logic [AW-1:0] addr,
   input logic          start_ev,
   input logic          stop_ev,
   input slv_state_e    state,
   input logic [7:0]    shift,
   input logic [6:0]    dev_addr
);

   // R5: a write strobe lasts one cycle
   a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !we);

   // R5, R8: the pointer steps by one (mod 2^AW) after each store
   a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (addr == AW'($past(addr) + 1'b1)));

   // R3: stores happen only in the acknowledge slot of a data byte
   a_r3_we_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (state == S_WACK));

   // R2: the address acknowledge is given only for a matching address
   a_r2_ack_match: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_AACK) |-> (shift[7:1] == dev_addr && sda_low));

   // R9: a START enters address reception
   a_r9_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ev && !stop_ev) |=> (state == S_ADDR));

   // R9: a STOP returns to idle with SDA released
   a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (state == S_IDLE && !sda_low));

   // R7: idle never pulls SDA
   a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE) |-> !sda_low);

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sda_low  (sda_drive_low_o),
   .we       (mem_we_o),
   .addr     (mem_addr_o),
   .start_ev (start_w),
   .stop_ev  (stop_w),
   .state    (state_w),
   .shift    (shift_w),
   .dev_addr (dev_addr_i)
);

// File: tb/sim_i2c_mem_slave.sv
`timescale 1ns/1ps
module sim_i2c_mem_slave;

   localparam int AW    = 9;
   localparam int FL    = 3;
   localparam int DEPTH = 1 << AW;
   localparam int H     = 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          m_scl, m_sda_low;
   logic [6:0]    dev_addr;
   logic          dut_low, we;
   logic [AW-1:0] addr;
   logic [7:0]    wdata, rdata;
   logic          sda_line;
   logic [7:0]    mem [0:DEPTH-1];
   logic [7:0]    exp_mem [0:DEPTH-1];
   int            n_chk = 0, n_err = 0, we_cnt = 0;

   always #2.5 clk = ~clk;

   assign sda_line = ~(m_sda_low | dut_low);
   assign rdata    = mem[addr];

   i2c_mem_slave #(.AW(AW), .FILT_LEN(FL)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .dev_addr_i(dev_addr), .sda_drive_low_o(dut_low), .mem_addr_o(addr),
      .mem_wdata_o(wdata), .mem_we_o(we), .mem_rdata_i(rdata));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else if (we) begin
         mem[addr] <= wdata;
         we_cnt    <= we_cnt + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int wrap(input int a);
      return a % DEPTH;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      m_sda_low = 1'b0; tick(H);
      m_scl = 1'b1;     tick(H);
      m_sda_low = 1'b1; tick(H);
      m_scl = 1'b0;     tick(2);
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1; tick(H);
      m_scl = 1'b1;     tick(H);
      m_sda_low = 1'b0; tick(H);
   endtask

   // gl: 0 none, 1 short SCL pulse in low phase, 2 short SDA dip in high phase
   task automatic send_bit(input logic b, input int gl);
      tick(2);
      m_sda_low = ~b;
      if (gl == 1) begin
         tick(H/2 - 2); m_scl = 1'b1; tick(FL-1); m_scl = 1'b0; tick(H/2 - FL + 1);
      end else begin
         tick(H - 2);
      end
      m_scl = 1'b1;
      if (gl == 2) begin
         tick(H/2); m_sda_low = 1'b1; tick(FL-1); m_sda_low = ~b; tick(H/2 - FL + 1);
      end else begin
         tick(H);
      end
      m_scl = 1'b0;
   endtask

   task automatic recv_bit(output logic b);
      tick(2);
      m_sda_low = 1'b0;
      tick(H - 2);
      m_scl = 1'b1;
      tick(H/2);
      b = sda_line;
      tick(H/2);
      m_scl = 1'b0;
   endtask

   task automatic write_byte(input logic [7:0] d, output logic ack, input int gl);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i], (i == 4) ? gl : 0);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic read_byte(output logic [7:0] d, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~ack, 0);
   endtask

   task automatic set_ptr(input logic [6:0] a, input int ptr);
      logic ack;
      bus_start();
      write_byte({a, 1'b0}, ack, 0); chk("R2 write header ack", ack, 1);
      write_byte(8'(ptr >> 8), ack, 0); chk("R4 pointer high ack", ack, 1);
      write_byte(8'(ptr), ack, 0);      chk("R4 pointer low ack", ack, 1);
   endtask

   task automatic do_write(input logic [6:0] a, input int ptr, input int len, input int gl);
      logic ack;
      logic [7:0] d;
      set_ptr(a, ptr);
      for (int i = 0; i < len; i++) begin
         d = (gl == 2) ? 8'hF7 : 8'($urandom);
         write_byte(d, ack, gl);
         chk("R5 data ack", ack, 1);
         exp_mem[wrap(ptr + i)] = d;
      end
      bus_stop();
      chk("R5 pointer after writes", int'(addr), wrap(ptr + len));
   endtask

   task automatic do_read(input logic [6:0] a, input int ptr, input int len);
      logic ack;
      logic [7:0] d;
      int bad;
      set_ptr(a, ptr);
      bus_start();
      write_byte({a, 1'b1}, ack, 0);
      chk("R9 repeated start read header ack", ack, 1);
      for (int i = 0; i < len; i++) begin
         read_byte(d, i != len - 1);
         chk("R6 read data", d, exp_mem[wrap(ptr + i)]);
      end
      bad = 0;
      for (int i = 0; i < 3 * H; i++) begin
         tick(1);
         if (dut_low) bad++;
      end
      chk("R7 SDA released after NACK", bad, 0);
      bus_stop();
      chk("R8 pointer after reads", int'(addr), wrap(ptr + len));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic ack;
      int   w0;
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
      m_scl = 1'b1; m_sda_low = 1'b0; dev_addr = 7'h5A;
      rst_n = 1'b0;
      tick(5);
      chk("R1 SDA released in reset", dut_low, 0);
      chk("R1 no strobe in reset", we, 0);
      rst_n = 1'b1;
      tick(10);
      chk("R1 SDA released after reset", dut_low, 0);
      chk("R1 pointer zero after reset", int'(addr), 0);

      // R2 R4 R5 R6: directed write and read back
      do_write(7'h5A, 9'h110, 3, 0);
      do_read(7'h5A, 9'h110, 3);

      // R3: mismatching address is ignored
      w0 = we_cnt;
      bus_start();
      write_byte({7'h5B, 1'b0}, ack, 0); chk("R3 no ack on mismatch", ack, 0);
      write_byte(8'h00, ack, 0);         chk("R3 no ack after mismatch", ack, 0);
      write_byte(8'h10, ack, 0);         chk("R3 no ack after mismatch", ack, 0);
      write_byte(8'hAA, ack, 0);         chk("R3 no ack after mismatch", ack, 0);
      bus_stop();
      bus_start();
      write_byte({7'h1A, 1'b1}, ack, 0); chk("R3 no ack on read mismatch", ack, 0);
      bus_stop();
      chk("R3 no stores after mismatch", we_cnt, w0);
      do_read(7'h5A, 9'h110, 1);

      // R9: a STOP ends the transfer, later bytes are ignored
      do_write(7'h5A, 9'h020, 1, 0);
      w0 = we_cnt;
      m_scl = 1'b0; tick(H);
      write_byte(8'h55, ack, 0); chk("R9 no ack after STOP", ack, 0);
      m_scl = 1'b1; tick(H);
      chk("R9 no store after STOP", we_cnt, w0);

      // R8: wrap at the top of the space
      do_write(7'h5A, DEPTH - 1, 2, 0);
      do_read(7'h5A, DEPTH - 1, 2);

      // R10: short pulses on SCL and SDA
      do_write(7'h5A, 9'h040, 2, 1);
      do_write(7'h5A, 9'h042, 2, 2);
      do_read(7'h5A, 9'h040, 4);

      // random transfers
      for (int t = 0; t < 12; t++) begin
         int p, l;
         dev_addr = 7'($urandom);
         p = $urandom % DEPTH;
         l = 1 + ($urandom % 5);
         do_write(dev_addr, p, l, 0);
         do_read(dev_addr, p, l);
      end

      w0 = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] !== exp_mem[i]) w0++;
      chk("R5 memory image mismatches", w0, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule